// File: doc/BRIEF.md
# Two-Channel Event Performance Counter

This block is a small performance monitoring unit with two event counters behind a simple word-addressed register bus. Each counter has a control word and a read-only count word. The control word picks an event code and holds three gating bits. The counter advances only when all three gating bits are set and the selected event fires in that cycle. A shared status word carries a self-clearing clear strobe for each counter, a sticky overflow flag for each counter, and a control that chains counter 1 onto the wraps of counter 0.

Event sources arrive as single-cycle pulses on an indexed strobe vector. A small decoder in each counter compares the programmed event code against the supported set. One code counts every cycle. Codes outside the set never count. When a counter wraps it returns to zero and raises its overflow flag. The interrupt output is high while either flag is set.

Software programs a counter in a fixed order: clear it, load the event code and mode bits, then set count-enable. Setting or clearing count-enable alone pauses or resumes the counter without losing the count or the event selection.

Top module: `perf_cnt_pair`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: A control word (word address 0 for counter 0, 1 for counter 1) stores the event code in bits 16:6, count-enable in bit 3, the mode bit in bit 1 and the unit-enable bit in bit 0. Every other bit reads back as 0.
- R3: A counter advances by one on a rising clock edge only if its count-enable, mode and unit-enable bits are all 1 and its selected event fires in that cycle. Otherwise it holds its value.
- R4: Clearing count-enable pauses the counter and keeps its event code. Setting it again resumes counting from the held value.
- R5: Event code 0x000 counts every cycle. Codes 0x202, 0x204, 0x029 and 0x02a count pulses on `evt_i` bits 0, 1, 2 and 3. Any other code never counts.
- R6: In the status word (word address 8), writing 1 to bit 1 clears counter 0 and its overflow flag, and writing 1 to bit 9 does the same for counter 1. A clear wins over an increment in the same cycle, so the counter reads 0 on the next cycle. Both clear bits always read as 0.
- R7: A counter at its all-ones value wraps to 0 on its next increment and sets its sticky overflow flag. The flags read at status bits 3 (counter 0) and 11 (counter 1) and hold until that counter is cleared. `irq_o` is the OR of the two flags.
- R8: While status bit 10 is 1, counter 1 increments on each wrap of counter 0 instead of on its own event. Its three gating bits still apply. Bit 10 reads back as written.
- R9: Writes of 1 to status bits 0, 8, 16 and 24, or to the overflow bits 3 and 11, have no effect. Those bits read as 0 unless an overflow flag is set.
- R10: Count words are at word addresses 4 (counter 0) and 5 (counter 1) and ignore writes. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| evt_i | input | NUM_EVT | Single-cycle event pulses |
| irq_o | output | 1 | High while any overflow flag is set |

## Verification
The counters are driven with a pseudo-random event pulse pattern under each supported code, under unsupported codes and under the every-cycle code. Against one reference count this separates a wrong code-to-strobe mapping from a missing gate. Partial gating patterns (count-enable without unit-enable, mode bits without count-enable) confirm that each of the three bits gates counting on its own. Long every-cycle runs drive each counter through its wrap, with and without chaining, which exposes off-by-one errors in wrap detection and in the flag and interrupt timing. Clears issued during active counting, and writes of 1 to reserved and flag bits, check clear priority and confirm those writes are ignored.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int NUM_CNT  = 2;
  localparam int NUM_EVT  = 4;
  localparam int CODE_W   = 11;
  localparam int DATA_W   = 32;

  // word addresses
  localparam int A_CTRL0  = 0;
  localparam int A_CTRL1  = 1;
  localparam int A_CNT0   = 4;
  localparam int A_CNT1   = 5;
  localparam int A_STAT   = 8;

  // control word fields
  localparam int C_CODE_LO = 6;
  localparam int C_CEN     = 3;
  localparam int C_MODE    = 1;
  localparam int C_UEN     = 0;

  // status word fields
  localparam int S_CLR0    = 1;
  localparam int S_OVF0    = 3;
  localparam int S_CLR1    = 9;
  localparam int S_CHAIN   = 10;
  localparam int S_OVF1    = 11;

  localparam logic [CODE_W-1:0] CODE_CYCLES = 11'h000;
  localparam logic [CODE_W-1:0] EVT_CODE [NUM_EVT] =
    '{11'h202, 11'h204, 11'h029, 11'h02a};

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              cen;
    logic              mode;
    logic              uen;
  } ctrl_t;
endpackage

// File: rtl/perf_evt_decode.sv
module perf_evt_decode
  import perf_cnt_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              hit_o
);
  logic [N_EVT-1:0] match;

  for (genvar g = 0; g < N_EVT; g++) begin : g_match
    assign match[g] = (code_i == EVT_CODE[g]) && evt_i[g];
  end

  assign hit_o = (code_i == CODE_CYCLES) || (|match);
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_EVT = NUM_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  ctrl_t            ctrl_d_i,
  input  logic             clr_i,
  input  logic             chain_sel_i,
  input  logic             chain_i,
  input  logic [N_EVT-1:0] evt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic             inc_o,
  output logic             wrap_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  perf_evt_decode #(.N_EVT(N_EVT)) u_dec (
    .code_i (ctrl_q.code),
    .evt_i  (evt_i),
    .hit_o  (hit)
  );

  assign act_o  = ctrl_q.cen && ctrl_q.mode && ctrl_q.uen;
  assign inc_o  = act_o && (chain_sel_i ? chain_i : hit);
  assign wrap_o = inc_o && !clr_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/perf_stat_reg.sv
module perf_stat_reg
  import perf_cnt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_CNT-1:0] wrap_i,
  output logic [NUM_CNT-1:0] clr_o,
  output logic               chain_o,
  output logic [NUM_CNT-1:0] ovf_o
);
  logic [NUM_CNT-1:0] ovf_q;
  logic               chain_q;

  assign clr_o[0] = we_i && wdata_i[S_CLR0];
  assign clr_o[1] = we_i && wdata_i[S_CLR1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= 1'b0;
    end else if (we_i) begin
      chain_q <= wdata_i[S_CHAIN];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ovf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovf_q[g] <= 1'b0;
      end else if (clr_o[g]) begin
        ovf_q[g] <= 1'b0;
      end else if (wrap_i[g]) begin
        ovf_q[g] <= 1'b1;
      end
    end
  end

  assign chain_o = chain_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/perf_cnt_pair.sv
module perf_cnt_pair
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int N_EVT   = NUM_EVT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL0 = ADDR_W'(A_CTRL0);
  localparam logic [ADDR_W-1:0] AD_CTRL1 = ADDR_W'(A_CTRL1);
  localparam logic [ADDR_W-1:0] AD_CNT0  = ADDR_W'(A_CNT0);
  localparam logic [ADDR_W-1:0] AD_CNT1  = ADDR_W'(A_CNT1);
  localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);

  ctrl_t              ctrl_d;
  ctrl_t              ctrl   [NUM_CNT];
  logic [CNT_W-1:0]   cnt    [NUM_CNT];
  logic [NUM_CNT-1:0] ctrl_we;
  logic [NUM_CNT-1:0] act;
  logic [NUM_CNT-1:0] inc;
  logic [NUM_CNT-1:0] wrap;
  logic [NUM_CNT-1:0] clr;
  logic [NUM_CNT-1:0] ovf;
  logic [NUM_CNT-1:0] chain_sel;
  logic [NUM_CNT-1:0] chain_src;
  logic               chain;
  logic               stat_we;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[31:17], wdata_i[5:4], wdata_i[2]};

  assign ctrl_d.code = wdata_i[C_CODE_LO +: CODE_W];
  assign ctrl_d.cen  = wdata_i[C_CEN];
  assign ctrl_d.mode = wdata_i[C_MODE];
  assign ctrl_d.uen  = wdata_i[C_UEN];

  assign ctrl_we[0] = wr_en_i && (addr_i == AD_CTRL0);
  assign ctrl_we[1] = wr_en_i && (addr_i == AD_CTRL1);
  assign stat_we    = wr_en_i && (addr_i == AD_STAT);

  // counter 0 always counts its own event; counter 1 may follow counter 0 wraps
  assign chain_sel = {chain, 1'b0};
  assign chain_src = {wrap[0], 1'b0};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perf_cnt_slice #(.CNT_W(CNT_W), .N_EVT(N_EVT)) u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_we_i   (ctrl_we[g]),
      .ctrl_d_i    (ctrl_d),
      .clr_i       (clr[g]),
      .chain_sel_i (chain_sel[g]),
      .chain_i     (chain_src[g]),
      .evt_i       (evt_i),
      .ctrl_o      (ctrl[g]),
      .cnt_o       (cnt[g]),
      .act_o       (act[g]),
      .inc_o       (inc[g]),
      .wrap_o      (wrap[g])
    );
  end

  perf_stat_reg u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (stat_we),
    .wdata_i (wdata_i),
    .wrap_i  (wrap),
    .clr_o   (clr),
    .chain_o (chain),
    .ovf_o   (ovf)
  );

  function automatic logic [31:0] pack_ctrl(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[C_CODE_LO +: CODE_W] = c.code;
    w[C_CEN]  = c.cen;
    w[C_MODE] = c.mode;
    w[C_UEN]  = c.uen;
    return w;
  endfunction

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AD_CTRL0: rdata_o = pack_ctrl(ctrl[0]);
      AD_CTRL1: rdata_o = pack_ctrl(ctrl[1]);
      AD_CNT0:  rdata_o = 32'(cnt[0]);
      AD_CNT1:  rdata_o = 32'(cnt[1]);
      AD_STAT: begin
        rdata_o[S_OVF0]  = ovf[0];
        rdata_o[S_OVF1]  = ovf[1];
        rdata_o[S_CHAIN] = chain;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |ovf;
endmodule

// File: rtl/perf_cnt_pair_chk.sv
module perf_cnt_pair_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       clr,
  input logic [1:0]       inc,
  input logic [1:0]       act,
  input logic [1:0]       wrap,
  input logic [1:0]       ovf,
  input logic             chain,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  AST_CLR_WINS_0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr[0] |=> (cnt0 == '0) && !ovf[0]); // R6
  AST_CLR_WINS_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr[1] |=> (cnt1 == '0) && !ovf[1]); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc[0] && !clr[0]) |=> $stable(cnt0)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[0] && !clr[0] && (&cnt0)) |=> (cnt0 == '0) && ovf[0]); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf[1] && !clr[1]) |=> ovf[1]); // R7
  AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wrap != 2'b00)); // R7
  AST_CHAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && act[1] && wrap[0] && !clr[1]) |=> (cnt1 == $past(cnt1) + 1'b1)); // R8
endmodule

bind perf_cnt_pair perf_cnt_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr    (clr),
  .inc    (inc),
  .act    (act),
  .wrap   (wrap),
  .ovf    (ovf),
  .chain  (chain),
  .irq_o  (irq_o),
  .cnt0   (cnt[0]),
  .cnt1   (cnt[1])
);

// File: tb/perf_cnt_pair_tb_top.sv
module perf_cnt_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int ADDR_W     = 4;
  localparam longint MAXV   = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [3:0]        evt = '0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int lfsr = 32'h1d2c_3b4a;

  perf_cnt_pair #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .evt_i   (evt),
    .irq_o   (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit [10:0] m_code [2];
  bit        m_cen  [2];
  bit        m_mode [2];
  bit        m_uen  [2];
  longint    m_cnt  [2];
  bit        m_ovf  [2];
  bit        m_cat;

  function automatic bit evt_fires(bit [10:0] code, logic [3:0] e);
    case (code)
      11'h000: return 1'b1;
      11'h202: return e[0];
      11'h204: return e[1];
      11'h029: return e[2];
      11'h02a: return e[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
    logic [31:0] r;
    r = '0;
    case (int'(a))
      0, 1: r = {15'd0, m_code[a], 2'b00, m_cen[a], 1'b0, m_mode[a], m_uen[a]};
      4: r = 32'(m_cnt[0]);
      5: r = 32'(m_cnt[1]);
      8: begin r[3] = m_ovf[0]; r[10] = m_cat; r[11] = m_ovf[1]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_code[i] = '0; m_cen[i] = 0; m_mode[i] = 0; m_uen[i] = 0;
        m_cnt[i] = 0; m_ovf[i] = 0;
      end
      m_cat = 0;
    end else begin
      bit c0, c1, a0, a1, i0, i1, w0;
      c0 = wr_en && addr == 8 && wdata[1];
      c1 = wr_en && addr == 8 && wdata[9];
      a0 = m_cen[0] && m_mode[0] && m_uen[0];
      a1 = m_cen[1] && m_mode[1] && m_uen[1];
      i0 = a0 && evt_fires(m_code[0], evt);
      w0 = i0 && !c0 && m_cnt[0] == MAXV;
      i1 = a1 && (m_cat ? w0 : evt_fires(m_code[1], evt));
      if (c0) begin m_cnt[0] = 0; m_ovf[0] = 0; end
      else if (i0) begin
        if (m_cnt[0] == MAXV) begin m_cnt[0] = 0; m_ovf[0] = 1; end
        else m_cnt[0] = m_cnt[0] + 1;
      end
      if (c1) begin m_cnt[1] = 0; m_ovf[1] = 0; end
      else if (i1) begin
        if (m_cnt[1] == MAXV) begin m_cnt[1] = 0; m_ovf[1] = 1; end
        else m_cnt[1] = m_cnt[1] + 1;
      end
      if (wr_en && (addr == 0 || addr == 1)) begin
        m_code[addr[0]] = wdata[16:6];
        m_cen[addr[0]]  = wdata[3];
        m_mode[addr[0]] = wdata[1];
        m_uen[addr[0]]  = wdata[0];
      end
      if (wr_en && addr == 8) m_cat = wdata[10];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== m_read(addr) || irq !== (m_ovf[0] | m_ovf[1])) begin
        errors++;
        $display("FAIL MODEL addr=%0d rdata=%h exp=%h irq=%b exp=%b",
                 addr, rdata, m_read(addr), irq, m_ovf[0] | m_ovf[1]);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    evt = lfsr[3:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    step(); wr_en = 1'b1; addr = a; wdata = d;
    step(); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_lit(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    step(); addr = a;
    @(negedge clk); #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic rd_mdl(logic [ADDR_W-1:0] a, string tag);
    step(); addr = a;
    @(negedge clk); #1;
    checks++;
    if (rdata !== m_read(a)) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, m_read(a));
    end
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk); #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] codes [6] = '{11'h202, 11'h204, 11'h029, 11'h02a, 11'h203, 11'h400};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_lit(0, 0, "R1"); rd_lit(1, 0, "R1"); rd_lit(4, 0, "R1");
    rd_lit(5, 0, "R1"); rd_lit(8, 0, "R1"); chk_irq(1'b0, "R1");

    // R2 control layout, unsupported code 0x7ff never counts (R5)
    wr(0, 32'hFFFF_FFFF);
    rd_lit(0, 32'h0001_FFCB, "R2");
    idle(20);
    rd_lit(4, 0, "R5");

    // R10 count word read-only, unmapped address
    wr(4, 32'h55); rd_lit(4, 0, "R10");
    wr(3, 32'hFFFF_FFFF); rd_lit(3, 0, "R10");

    // R3 partial gating holds the count
    wr(0, 32'h3); idle(10); rd_lit(4, 0, "R3");
    wr(0, 32'hA); idle(10); rd_lit(4, 0, "R3");
    wr(0, 32'hB); idle(9); rd_mdl(4, "R3");

    // R4 pause and resume
    wr(0, 32'h3); rd_mdl(4, "R4"); idle(12); rd_mdl(4, "R4");
    rd_lit(0, 32'h3, "R4");
    wr(0, 32'hB); idle(7); rd_mdl(4, "R4");

    // R5 each code on both counters
    foreach (codes[k]) begin
      wr(8, 32'h202);
      wr(0, (32'(codes[k]) << 6) | 32'hB);
      wr(1, (32'(codes[(k + 1) % 6]) << 6) | 32'hB);
      idle(60);
      rd_mdl(4, "R5"); rd_mdl(5, "R5");
    end

    // R6 clear during every-cycle counting
    wr(8, 32'h202); wr(0, 32'hB); idle(15);
    wr(8, 32'h2); rd_mdl(4, "R6");
    rd_lit(8, 0, "R6");

    // R7 wrap of counter 0
    wr(8, 32'h2); idle(int'(MAXV) + 5);
    rd_mdl(8, "R7"); chk_irq(1'b1, "R7");
    idle(30); rd_lit(8, 32'h8, "R7");
    wr(8, 32'h2); chk_irq(1'b0, "R7");

    // R9 reserved and flag bits ignored on write
    wr(8, 32'h0101_0909);
    rd_lit(8, 0, "R9"); rd_mdl(4, "R9");

    // R8 chaining: counter 1 has unsupported code but follows wraps
    wr(8, 32'h602);
    wr(1, (32'h7ff << 6) | 32'hB);
    wr(0, 32'hB);
    idle(2 * int'(MAXV) + 40);
    rd_mdl(5, "R8"); rd_mdl(8, "R8");
    wr(1, (32'h7ff << 6) | 32'h3);
    idle(int'(MAXV) + 5);
    rd_mdl(5, "R8");

    // R7 counter 1 wrap on its own
    wr(8, 32'h202); wr(0, 32'h0); wr(1, 32'hB);
    idle(int'(MAXV) + 5);
    rd_lit(8, 32'h800, "R7"); chk_irq(1'b1, "R7");
    wr(8, 32'h200); rd_lit(8, 0, "R6");

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule